// File: doc/BRIEF.md
# Fixed-Point Nested-Loop Matrix Multiply Engine

This block multiplies a two-row, three-column matrix A by a three-row, two-column matrix B and leaves the two-by-two product in an on-chip result store. All scalars are signed 8.8 fixed point: 16 bits in total, 8 of them fractional. A host first fills the A and B stores through a valid/ready write port. It then pulses `start` and waits for `done`. After that it reads the four results back over a plain registered read port.

Once started, the engine spends one cycle per result element clearing the result store to zero. It then walks the iteration space with three cascaded counters: row `y` is the outermost, reduction index `k` is in the middle and column `x` is the innermost. It performs exactly one multiply-accumulate per clock. The flat row-major addresses and the fixed-point multiply are combinational between the counters and the stores. The result store is updated by a read-modify-write in the same cycle.

Back-pressure on the write port is simple. `wr_ready` is high exactly when the engine is idle. A word transfers on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the host holds its word and may keep `wr_valid` asserted until the engine finishes.

Top module: `fxmm_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, `wr_ready` is 1, and every result element reads back as 0.
- R2: A write transfers when `wr_valid` and `wr_ready` are both high at a clock edge. `wr_mat` selects the target store: 0 means A, stored at flat address k + y*3, and 1 means B, stored at flat address x + k*2. A write to an address of 6 or more changes nothing.
- R3: `rd_data` shows, one clock after `rd_addr` is presented, the result element at flat address x + y*2. Any `rd_addr` of 4 or more reads as 0.
- R4: A `start` sampled while idle raises `busy` on the next clock. `busy` then stays high for exactly 16 cycles: 4 cycles to clear the result store and 12 accumulate cycles.
- R5: `done` is high for exactly one cycle. It rises on the clock edge where `busy` falls, which follows the final accumulate at y=1, k=2, x=1.
- R6: The counters scan y over 0..1 (outer), k over 0..2 and x over 0..1 (inner). The x counter steps on every accumulate cycle. An outer counter steps only when the counter directly inside it is at its last value, so the 12 points are each visited once, one per cycle.
- R7: Each result element equals the sum over k of A[y,k]*B[k,x]. Each product is formed at 32 bits, shifted arithmetically right by 8 (so the fraction is truncated toward minus infinity) and cut to 16 bits. The products and the sum wrap on overflow and never saturate.
- R8: While `busy` is high, `wr_ready` is 0, so no write transfers, and a `start` pulse has no effect on the run in progress or on its result.
- R9: Each run clears the result store first, so repeating a run on unchanged inputs gives the same results rather than adding to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a run while the engine is idle |
| busy | output | 1 | High while clearing or accumulating |
| done | output | 1 | One-cycle pulse when a run has finished |
| wr_valid | input | 1 | Host write word is valid |
| wr_ready | output | 1 | Engine can accept a host write (idle) |
| wr_mat | input | 1 | Write target: 0 selects A, 1 selects B |
| wr_addr | input | 16 | Flat row-major element address within the target |
| wr_data | input | 16 | 8.8 signed value to store |
| rd_addr | input | 16 | Flat address of the result element to read |
| rd_data | output | 16 | Result element, registered one clock after `rd_addr` |

## Verification
The following are checked on every cycle:
- the counter cascade: an outer index holds unless the one inside it is at its last value, and a counter that is neither enabled nor cleared holds its value;
- that the computed addresses stay inside their stores;
- that a host write never coincides with an engine write to the result store;
- that `done` lasts one cycle and follows a busy cycle.

Only the bench's scenarios can show the following:
- the arithmetic results, which it checks for integer, fractional, negative and overflowing patterns, and for a sweep of generated matrices;
- the exact 16-cycle busy window;
- that a second run does not add onto the first;
- that writes and a `start` pulse arriving mid-run, and writes to out-of-range addresses, leave the result untouched.

// File: rtl/fxmm_pkg.sv
package fxmm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2
  } fxmm_state_t;
endpackage

// File: rtl/fxmm_counter.sv
module fxmm_counter #(
  parameter int LIMIT = 2,
  parameter int IW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [IW-1:0] cnt,
  output logic          at_end
);
  assign at_end = (cnt == IW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (en)      cnt <= at_end ? '0 : cnt + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt)); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt < IW'(LIMIT))); // R6
endmodule

// File: rtl/fxmm_loop_nest.sv
module fxmm_loop_nest #(
  parameter int ROWS  = 2,
  parameter int INNER = 3,
  parameter int COLS  = 2,
  parameter int IW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [IW-1:0] y,
  output logic [IW-1:0] k,
  output logic [IW-1:0] x,
  output logic          last
);
  localparam int LEVELS = 3;

  logic [LEVELS-1:0] lvl_end;
  logic [LEVELS-1:0] lvl_en;
  logic [IW-1:0]     lvl_cnt [LEVELS];

  // level 0 is innermost (x), level 2 outermost (y)
  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      localparam int LIM = (g == 0) ? COLS : ((g == 1) ? INNER : ROWS);
      if (g == 0) begin : g_inner
        assign lvl_en[g] = step;
      end else begin : g_outer
        assign lvl_en[g] = lvl_en[g-1] && lvl_end[g-1];
      end
      fxmm_counter #(.LIMIT(LIM), .IW(IW)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (lvl_en[g]),
        .cnt    (lvl_cnt[g]),
        .at_end (lvl_end[g])
      );
    end
  endgenerate

  assign x    = lvl_cnt[0];
  assign k    = lvl_cnt[1];
  assign y    = lvl_cnt[2];
  assign last = &lvl_end;

  AST_OUTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && x != IW'(COLS - 1)) |=> ($stable(k) && $stable(y))); // R6

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && k != IW'(INNER - 1)) |=> $stable(y)); // R6
endmodule

// File: rtl/fxmm_datapath.sv
module fxmm_datapath #(
  parameter int INNER = 3,
  parameter int COLS  = 2,
  parameter int IW    = 16,
  parameter int DW    = 16,
  parameter int FRAC  = 8
) (
  input  logic [IW-1:0] y,
  input  logic [IW-1:0] k,
  input  logic [IW-1:0] x,
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] b_val,
  input  logic [DW-1:0] acc_old,
  output logic [IW-1:0] a_addr,
  output logic [IW-1:0] b_addr,
  output logic [IW-1:0] o_addr,
  output logic [DW-1:0] acc_new
);
  localparam int PW = 2 * DW;

  logic signed [DW-1:0] sa, sb;
  logic signed [PW-1:0] prod;

  always_comb begin
    a_addr  = k + y * IW'(INNER);
    b_addr  = x + k * IW'(COLS);
    o_addr  = x + y * IW'(COLS);
    sa      = a_val;
    sb      = b_val;
    prod    = PW'(sa) * PW'(sb);
    acc_new = acc_old + DW'(prod >>> FRAC);
  end
endmodule

// File: rtl/fxmm_store.sv
module fxmm_store #(
  parameter int A_N = 6,
  parameter int B_N = 6,
  parameter int O_N = 4,
  parameter int IW  = 16,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en,
  input  logic          hw_mat,
  input  logic [IW-1:0] hw_addr,
  input  logic [DW-1:0] hw_data,
  input  logic [IW-1:0] a_raddr,
  output logic [DW-1:0] a_rdata,
  input  logic [IW-1:0] b_raddr,
  output logic [DW-1:0] b_rdata,
  input  logic          o_we,
  input  logic [IW-1:0] o_addr,
  input  logic [DW-1:0] o_wdata,
  output logic [DW-1:0] o_rdata,
  input  logic [IW-1:0] h_raddr,
  output logic [DW-1:0] h_rdata
);
  localparam int AAW = $clog2(A_N);
  localparam int BAW = $clog2(B_N);
  localparam int OAW = $clog2(O_N);

  logic [DW-1:0] mem_a [A_N];
  logic [DW-1:0] mem_b [B_N];
  logic [DW-1:0] mem_o [O_N];

  logic a_hit, b_hit;
  assign a_hit = hw_en && !hw_mat && (hw_addr < IW'(A_N));
  assign b_hit = hw_en &&  hw_mat && (hw_addr < IW'(B_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < A_N; i++) mem_a[i] <= '0;
      for (int i = 0; i < B_N; i++) mem_b[i] <= '0;
    end else begin
      if (a_hit) mem_a[hw_addr[AAW-1:0]] <= hw_data;
      if (b_hit) mem_b[hw_addr[BAW-1:0]] <= hw_data;
    end
  end

  assign a_rdata = (a_raddr < IW'(A_N)) ? mem_a[a_raddr[AAW-1:0]] : '0;
  assign b_rdata = (b_raddr < IW'(B_N)) ? mem_b[b_raddr[BAW-1:0]] : '0;
  assign o_rdata = (o_addr  < IW'(O_N)) ? mem_o[o_addr[OAW-1:0]]  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < O_N; i++) mem_o[i] <= '0;
      h_rdata <= '0;
    end else begin
      if (o_we && o_addr < IW'(O_N)) mem_o[o_addr[OAW-1:0]] <= o_wdata;
      h_rdata <= (h_raddr < IW'(O_N)) ? mem_o[h_raddr[OAW-1:0]] : '0;
    end
  end

  AST_HOST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en |-> !o_we); // R8
endmodule

// File: rtl/fxmm_engine.sv
module fxmm_engine #(
  parameter int ROWS  = 2,
  parameter int INNER = 3,
  parameter int COLS  = 2,
  parameter int IW    = 16,
  parameter int DW    = 16,
  parameter int FRAC  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_mat,
  input  logic [IW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  import fxmm_pkg::*;

  localparam int A_N = ROWS * INNER;
  localparam int B_N = INNER * COLS;
  localparam int O_N = ROWS * COLS;

  fxmm_state_t   state;
  logic [IW-1:0] clr_idx;
  logic          run, last;
  logic [IW-1:0] y, k, x;
  logic [IW-1:0] a_addr, b_addr, acc_addr;
  logic [DW-1:0] a_val, b_val, acc_old, acc_new;
  logic          o_we;
  logic [IW-1:0] o_addr;
  logic [DW-1:0] o_wdata;

  assign run      = (state == ST_RUN);
  assign busy     = (state != ST_IDLE);
  assign wr_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      clr_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_CLEAR;
          clr_idx <= '0;
        end
        ST_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == IW'(O_N - 1)) state <= ST_RUN;
        end
        ST_RUN: if (last) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  fxmm_loop_nest #(.ROWS(ROWS), .INNER(INNER), .COLS(COLS), .IW(IW)) i_nest (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run),
    .step  (run),
    .y     (y),
    .k     (k),
    .x     (x),
    .last  (last)
  );

  fxmm_datapath #(.INNER(INNER), .COLS(COLS), .IW(IW), .DW(DW), .FRAC(FRAC)) i_dp (
    .y       (y),
    .k       (k),
    .x       (x),
    .a_val   (a_val),
    .b_val   (b_val),
    .acc_old (acc_old),
    .a_addr  (a_addr),
    .b_addr  (b_addr),
    .o_addr  (acc_addr),
    .acc_new (acc_new)
  );

  assign o_we    = busy;
  assign o_addr  = (state == ST_CLEAR) ? clr_idx : acc_addr;
  assign o_wdata = (state == ST_CLEAR) ? '0 : acc_new;

  fxmm_store #(.A_N(A_N), .B_N(B_N), .O_N(O_N), .IW(IW), .DW(DW)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_en   (wr_valid && wr_ready),
    .hw_mat  (wr_mat),
    .hw_addr (wr_addr),
    .hw_data (wr_data),
    .a_raddr (a_addr),
    .a_rdata (a_val),
    .b_raddr (b_addr),
    .b_rdata (b_val),
    .o_we    (o_we),
    .o_addr  (o_addr),
    .o_wdata (o_wdata),
    .o_rdata (acc_old),
    .h_raddr (rd_addr),
    .h_rdata (rd_data)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy))); // R5

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(run && last)) |=> busy); // R4

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (a_addr < IW'(A_N) && b_addr < IW'(B_N) && acc_addr < IW'(O_N))); // R6
endmodule

// File: tb/test_fxmm_engine.sv
module test_fxmm_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, wr_ready;
  logic        wr_valid = 1'b0;
  logic        wr_mat = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic signed [15:0] ma [6];
  logic signed [15:0] mb [6];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  fxmm_engine i_fxmm_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_mat(wr_mat),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_elem(input int y, input int x);
    logic [15:0] acc = '0;
    logic signed [31:0] p;
    for (int kk = 0; kk < 3; kk++) begin
      p   = 32'(ma[kk + y*3]) * 32'(mb[x + kk*2]);
      acc = acc + 16'(p >>> 8);
    end
    return acc;
  endfunction

  task automatic host_write(input logic mat, input int addr, input logic [15:0] val);
    @(negedge clk);
    wr_valid = 1'b1; wr_mat = mat; wr_addr = 16'(addr); wr_data = val;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 6; i++) host_write(1'b0, i, ma[i]);
    for (int i = 0; i < 6; i++) host_write(1'b1, i, mb[i]);
  endtask

  task automatic read_res(input int addr, output logic [15:0] val);
    @(negedge clk);
    rd_addr = 16'(addr);
    @(negedge clk);
    val = rd_data;
  endtask

  // start a run; optionally poke start and a write in the middle of it
  task automatic do_run(input bit poke);
    int n = 0;
    @(negedge clk);
    check("R2 wr_ready idle", 32'(wr_ready), 32'd1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && n < 100) begin
      n++;
      if (poke && n == 5) begin
        start = 1'b1; wr_valid = 1'b1; wr_mat = 1'b0; wr_addr = '0; wr_data = 16'h7777;
        check("R8 wr_ready low while busy", 32'(wr_ready), 32'd0);
      end else begin
        start = 1'b0; wr_valid = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; wr_valid = 1'b0;
    check("R4 R6 busy cycle count", 32'(n), 32'd16);
    check("R5 done at busy fall", 32'(done), 32'd1);
    @(negedge clk);
    check("R5 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic check_results(input string req);
    logic [15:0] v;
    for (int yy = 0; yy < 2; yy++)
      for (int xx = 0; xx < 2; xx++) begin
        read_res(xx + yy*2, v);
        check(req, 32'(v), 32'(ref_elem(yy, xx)));
      end
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 wr_ready", 32'(wr_ready), 32'd1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      read_res(i, v);
      check("R1 result zero", 32'(v), 32'd0);
    end

    // integers 1..6 (R7)
    for (int i = 0; i < 6; i++) begin ma[i] = 16'((i+1) << 8); mb[i] = 16'((i+1) << 8); end
    load_all();
    do_run(1'b0);
    read_res(0, v); check("R7 int y0x0", 32'(v), 32'd5632);
    read_res(1, v); check("R7 int y0x1", 32'(v), 32'd7168);
    read_res(2, v); check("R7 int y1x0", 32'(v), 32'd12544);
    read_res(3, v); check("R7 int y1x1", 32'(v), 32'd16384);
    read_res(4, v); check("R3 read beyond range", 32'(v), 32'd0);

    // out-of-range writes ignored, rerun not accumulated (R2, R9)
    host_write(1'b0, 6, 16'h5a5a);
    host_write(1'b1, 7, 16'h5a5a);
    host_write(1'b0, 16'hffff, 16'h5a5a);
    do_run(1'b0);
    check_results("R9 R2 rerun unchanged");

    // fractional and negative (R7), with mid-run start and write (R8)
    ma[0] = -16'sd384; ma[1] = 16'sd64;   ma[2] = 16'sd704;
    ma[3] = -16'sd32;  ma[4] = 16'sd768;  ma[5] = -16'sd512;
    mb[0] = 16'sd128;  mb[1] = -16'sd256; mb[2] = 16'sd385;
    mb[3] = -16'sd193; mb[4] = -16'sd768; mb[5] = 16'sd17;
    load_all();
    do_run(1'b1);
    check_results("R8 R7 frac/neg with mid-run poke");

    // overflow wraps (R7)
    for (int i = 0; i < 6; i++) begin ma[i] = 16'sd25600; mb[i] = (i % 2 == 0) ? 16'sd25600 : -16'sd32768; end
    load_all();
    do_run(1'b0);
    check_results("R7 overflow wrap");

    // generated sweep (R7)
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 6; i++) begin
        seed = seed * 32'd1103515245 + 32'd12345; ma[i] = seed[23:8];
        seed = seed * 32'd1103515245 + 32'd12345; mb[i] = seed[23:8];
      end
      load_all();
      do_run(1'b0);
      check_results("R7 sweep");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule